// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between the device pins and the core interrupt controller. It conditions sixteen external interrupt lines and one non-maskable line. Every line is brought into the clock domain by a synchronizer. A history flop then compares the synchronized value with the value from the cycle before, so that edges can be detected.

Each external line has its own sense mode: rising edge, falling edge, either edge, high level, low level, or off. Edge events set a sticky flag that software clears. A level flag tracks the synchronized pin. A per-pin select input tells whether the pin is wired to the interrupt function or left as general-purpose I/O. A per-line wake enable adds the line to a wake request that has no clock in its path, so the request still works while the system clock is stopped.

The non-maskable line has its own sense field and its own detector. It does not depend on the pin selects or on the line configuration, and the off code silences it.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset, `irq_flag`, `nmi_req` and `wake_req` are 0. Every line and the non-maskable input start in the off mode, so pin activity sets nothing until a mode is written.
- R2: The sense codes are 0 off, 1 rising, 2 falling, 3 either edge, 4 high level and 5 low level. Codes 6 and 7 behave as off. A line in the off mode holds its flag at 0 from the next clock edge onward.
- R3: A pin change that is present before clock edge k shows in the flags after edge k+2. The path is two synchronizer flops followed by the flag register.
- R4: An edge-mode flag stays at 1 until `flag_clr` for that line is 1 at a clock edge. If a new edge event and a clear arrive at the same edge, the flag stays at 1.
- R5: A level-mode flag equals the synchronized pin level compared with the mode polarity, with the latency given in R3. `flag_clr` has no effect on it.
- R6: When `pin_sel` for a line is 0, that line sets no edge flag, its level flag is 0, and it adds nothing to `wake_req`.
- R7: `wake_req` is the OR over the lines that have wake enabled and are selected. A line counts when its raw pin is high in modes 1 and 4, when it is low in modes 2 and 5, and when the raw pin differs from its synchronized value in mode 3. No clock is involved, so the request also responds while the clock is stopped.
- R8: `nmi_req` uses its own sense field, written through `nmi_we`/`nmi_sense`, with the same codes and latency as the external lines. An edge pending is cleared by `nmi_clr`. The pin selects and the line configuration do not affect it, and the off code keeps it at 0.
- R9: A configuration write (`cfg_we`, `cfg_line`, `cfg_sense`, `cfg_wake_en`) changes only the addressed line and takes effect at the next edge. Clears and configuration of one line leave all other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_LINES | Raw external interrupt pins |
| pin_sel | input | NUM_LINES | 1 = pin routed to the interrupt function, 0 = general-purpose I/O |
| nmi_pin | input | 1 | Raw non-maskable interrupt pin |
| cfg_we | input | 1 | Line configuration write strobe |
| cfg_line | input | IDX_W | Index of the line being configured |
| cfg_sense | input | 3 | Sense code to write |
| cfg_wake_en | input | 1 | Wake enable to write |
| flag_clr | input | NUM_LINES | Write-one clear for the edge flags |
| nmi_we | input | 1 | Non-maskable sense write strobe |
| nmi_sense | input | 3 | Non-maskable sense code to write |
| nmi_clr | input | 1 | Clear for a pending non-maskable edge |
| irq_flag | output | NUM_LINES | Per-line interrupt flags |
| nmi_req | output | 1 | Non-maskable interrupt request |
| wake_req | output | 1 | Asynchronous wake request |

## Verification
The checker verifies the following properties on every clock cycle:
- Off lines keep their flags at 0.
- Edge flags persist while no clear is given.
- Deselected lines never raise a flag.
- The non-maskable output stays quiet in the off mode.
- A wake request never appears without a line that is both enabled and selected.

Some behaviours can only be shown by the bench's scenarios:
- The exact three-edge latency.
- A set that coincides with a clear.
- The level flag ignoring clears.
- The wake request tracking pin changes while the clock is held stopped.
- The interaction of random configuration writes with pin traffic, which is compared against a cycle model built from the requirements.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;

   localparam int SENSE_W = 3;

   typedef enum logic [SENSE_W-1:0] {
      SENSE_OFF  = 3'd0,
      SENSE_RISE = 3'd1,
      SENSE_FALL = 3'd2,
      SENSE_BOTH = 3'd3,
      SENSE_HIGH = 3'd4,
      SENSE_LOW  = 3'd5
   } sense_e;

   // Edge-sensitive codes: rising, falling, either edge
   function automatic logic is_edge_mode(logic [SENSE_W-1:0] m);
      return (m == SENSE_RISE) || (m == SENSE_FALL) || (m == SENSE_BOTH);
   endfunction

   // Level-sensitive codes: high, low
   function automatic logic is_level_mode(logic [SENSE_W-1:0] m);
      return (m == SENSE_HIGH) || (m == SENSE_LOW);
   endfunction

endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("extint_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/extint_line.sv
`timescale 1ns/1ps
module extint_line
   import extint_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_WAKE    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin,
   input  logic               sel,
   input  logic [SENSE_W-1:0] mode,
   input  logic               wake_en,
   input  logic               clr,
   output logic               flag,
   output logic               wake
);

   logic s_sync;
   logic s_hist;
   logic rise, fall;
   logic evt;
   logic lvl;
   logic flag_q;

   extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (s_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_hist <= 1'b0;
      else        s_hist <= s_sync;
   end

   assign rise = s_sync & ~s_hist;
   assign fall = ~s_sync & s_hist;

   always_comb begin
      evt = 1'b0;
      lvl = 1'b0;
      case (mode)
         SENSE_RISE: evt = rise;
         SENSE_FALL: evt = fall;
         SENSE_BOTH: evt = rise | fall;
         SENSE_HIGH: lvl = s_sync;
         SENSE_LOW:  lvl = ~s_sync;
         default:    ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   flag_q <= 1'b0;
      else if (is_level_mode(mode)) flag_q <= sel & lvl;
      else if (is_edge_mode(mode))  flag_q <= (flag_q & ~clr) | (sel & evt);
      else                          flag_q <= 1'b0;
   end

   assign flag = flag_q;

   generate
      if (HAS_WAKE) begin : g_wake
         logic wake_raw;
         always_comb begin
            case (mode)
               SENSE_RISE, SENSE_HIGH: wake_raw = pin;
               SENSE_FALL, SENSE_LOW:  wake_raw = ~pin;
               SENSE_BOTH:             wake_raw = pin ^ s_sync;
               default:                wake_raw = 1'b0;
            endcase
         end
         assign wake = wake_en & sel & wake_raw;
      end else begin : g_nowake
         logic unused_wake_en;
         assign unused_wake_en = wake_en;
         assign wake = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/extint_sense_ctrl.sv
`timescale 1ns/1ps
module extint_sense_ctrl
   import extint_pkg::*;
#(
   parameter  int NUM_LINES   = 16,
   parameter  int SYNC_STAGES = 2,
   parameter  bit WAKE_PATH   = 1'b1,
   localparam int IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_in,
   input  logic [NUM_LINES-1:0] pin_sel,
   input  logic                 nmi_pin,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_line,
   input  logic [SENSE_W-1:0]   cfg_sense,
   input  logic                 cfg_wake_en,
   input  logic [NUM_LINES-1:0] flag_clr,
   input  logic                 nmi_we,
   input  logic [SENSE_W-1:0]   nmi_sense,
   input  logic                 nmi_clr,
   output logic [NUM_LINES-1:0] irq_flag,
   output logic                 nmi_req,
   output logic                 wake_req
);

   generate
      if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
         $error("extint_sense_ctrl: NUM_LINES must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("extint_sense_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SENSE_W-1:0]   mode_q [NUM_LINES];
   logic [NUM_LINES-1:0] wen_q;
   logic [SENSE_W-1:0]   nmi_mode_q;
   logic [NUM_LINES-1:0] wake_vec;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
         logic hit;
         assign hit = cfg_we && (cfg_line == IDX_W'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mode_q[gi] <= SENSE_OFF;
               wen_q[gi]  <= 1'b0;
            end else if (hit) begin
               mode_q[gi] <= cfg_sense;
               wen_q[gi]  <= cfg_wake_en;
            end
         end

         extint_line #(
            .SYNC_STAGES (SYNC_STAGES),
            .HAS_WAKE    (WAKE_PATH)
         ) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pin_in[gi]),
            .sel     (pin_sel[gi]),
            .mode    (mode_q[gi]),
            .wake_en (wen_q[gi]),
            .clr     (flag_clr[gi]),
            .flag    (irq_flag[gi]),
            .wake    (wake_vec[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      nmi_mode_q <= SENSE_OFF;
      else if (nmi_we) nmi_mode_q <= nmi_sense;
   end

   logic nmi_wake_unused;

   extint_line #(
      .SYNC_STAGES (SYNC_STAGES),
      .HAS_WAKE    (1'b0)
   ) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (nmi_pin),
      .sel     (1'b1),
      .mode    (nmi_mode_q),
      .wake_en (1'b0),
      .clr     (nmi_clr),
      .flag    (nmi_req),
      .wake    (nmi_wake_unused)
   );

   assign wake_req = |wake_vec;

endmodule

// File: rtl/extint_sense_chk.sv
`timescale 1ns/1ps
module extint_sense_chk
   import extint_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] pin_sel,
   input logic [NUM_LINES-1:0] flag_clr,
   input logic [NUM_LINES-1:0] irq_flag,
   input logic                 nmi_req,
   input logic                 wake_req,
   input logic [SENSE_W-1:0]   mode_q [NUM_LINES],
   input logic [NUM_LINES-1:0] wen_q,
   input logic [SENSE_W-1:0]   nmi_mode_q
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_chk
         // R2
         off_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_edge_mode(mode_q[gi]) && !is_level_mode(mode_q[gi])) |=> !irq_flag[gi]);

         // R4
         edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flag[gi] && is_edge_mode(mode_q[gi]) && !flag_clr[gi]) |=> irq_flag[gi]);

         // R6
         unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_sel[gi] && !irq_flag[gi]) |=> !irq_flag[gi]);
      end
   endgenerate

   // R8
   nmi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_edge_mode(nmi_mode_q) && !is_level_mode(nmi_mode_q)) |=> !nmi_req);

   // R7
   wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ((wen_q & pin_sel) != '0));

endmodule

bind extint_sense_ctrl extint_sense_chk #(
   .NUM_LINES (NUM_LINES),
   .IDX_W     (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_sel    (pin_sel),
   .flag_clr   (flag_clr),
   .irq_flag   (irq_flag),
   .nmi_req    (nmi_req),
   .wake_req   (wake_req),
   .mode_q     (mode_q),
   .wen_q      (wen_q),
   .nmi_mode_q (nmi_mode_q)
);

// File: tb/sim_extint_sense_ctrl.sv
`timescale 1ns/1ps
module sim_extint_sense_ctrl;

   localparam int N = 16;

   logic clk = 1'b0;
   logic clk_en = 1'b1;
   logic rst_n = 1'b0;
   logic [N-1:0] pin_in = '0, pin_sel = '0, flag_clr = '0;
   logic nmi_pin = 1'b0, cfg_we = 1'b0, cfg_wake_en = 1'b0;
   logic nmi_we = 1'b0, nmi_clr = 1'b0;
   logic [3:0] cfg_line = '0;
   logic [2:0] cfg_sense = '0, nmi_sense = '0;
   logic [N-1:0] irq_flag;
   logic nmi_req, wake_req;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   always #2.5 if (clk_en) clk = ~clk;

   extint_sense_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sel(pin_sel),
      .nmi_pin(nmi_pin), .cfg_we(cfg_we), .cfg_line(cfg_line),
      .cfg_sense(cfg_sense), .cfg_wake_en(cfg_wake_en), .flag_clr(flag_clr),
      .nmi_we(nmi_we), .nmi_sense(nmi_sense), .nmi_clr(nmi_clr),
      .irq_flag(irq_flag), .nmi_req(nmi_req), .wake_req(wake_req)
   );

   // Reference model state, built from the requirements
   logic [N-1:0] m_s0 = '0, m_s1 = '0, m_h = '0, m_flag = '0, m_wen = '0;
   logic [2:0]   m_mode [N];
   logic n_s0 = 0, n_s1 = 0, n_h = 0, m_nmi = 0;
   logic [2:0] m_nmode = '0;

   function automatic logic next_flag(logic [2:0] md, logic s, logic h,
                                      logic sel, logic clr, logic f);
      case (md)
         3'd1: return (f & ~clr) | (sel & s & ~h);
         3'd2: return (f & ~clr) | (sel & ~s & h);
         3'd3: return (f & ~clr) | (sel & (s ^ h));
         3'd4: return sel & s;
         3'd5: return sel & ~s;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic exp_wake();
      logic w = 1'b0;
      for (int i = 0; i < N; i++) begin
         logic raw;
         case (m_mode[i])
            3'd1, 3'd4: raw = pin_in[i];
            3'd2, 3'd5: raw = ~pin_in[i];
            3'd3:       raw = pin_in[i] ^ m_s1[i];
            default:    raw = 1'b0;
         endcase
         w |= m_wen[i] & pin_sel[i] & raw;
      end
      return w;
   endfunction

   task automatic model_edge();
      logic [N-1:0] nf;
      logic nn;
      if (!rst_n) begin
         m_s0 = '0; m_s1 = '0; m_h = '0; m_flag = '0; m_wen = '0;
         for (int i = 0; i < N; i++) m_mode[i] = 3'd0;
         n_s0 = 0; n_s1 = 0; n_h = 0; m_nmi = 0; m_nmode = '0;
         return;
      end
      for (int i = 0; i < N; i++)
         nf[i] = next_flag(m_mode[i], m_s1[i], m_h[i], pin_sel[i], flag_clr[i], m_flag[i]);
      nn = next_flag(m_nmode, n_s1, n_h, 1'b1, nmi_clr, m_nmi);
      m_h = m_s1; m_s1 = m_s0; m_s0 = pin_in;
      n_h = n_s1; n_s1 = n_s0; n_s0 = nmi_pin;
      m_flag = nf; m_nmi = nn;
      if (cfg_we) begin
         m_mode[cfg_line] = cfg_sense;
         m_wen[cfg_line]  = cfg_wake_en;
      end
      if (nmi_we) m_nmode = nmi_sense;
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(cur_req, "irq_flag", 32'(irq_flag), 32'(m_flag));
      chk(cur_req, "nmi_req", 32'(nmi_req), 32'(m_nmi));
      chk(cur_req, "wake_req", 32'(wake_req), 32'(exp_wake()));
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr_cfg(int line, logic [2:0] md, logic wen);
      cfg_we = 1'b1; cfg_line = 4'(line); cfg_sense = md; cfg_wake_en = wen;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic wr_nmi(logic [2:0] md);
      nmi_we = 1'b1; nmi_sense = md;
      step();
      nmi_we = 1'b0;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0123));
      for (int i = 0; i < N; i++) m_mode[i] = 3'd0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "irq_flag in reset", 32'(irq_flag), 0);
      chk("R1", "nmi_req in reset", 32'(nmi_req), 0);
      chk("R1", "wake_req in reset", 32'(wake_req), 0);
      rst_n = 1'b1;
      pin_sel = '1;
      for (int k = 0; k < 20; k++) begin
         pin_in = 16'($urandom); nmi_pin = 1'($urandom);
         step();
         chk("R1", "unconfigured flags", 32'(irq_flag), 0);
      end
      pin_in = '0; nmi_pin = 1'b0;
      repeat (4) step();

      // R3: latency of a rising edge
      cur_req = "R3";
      wr_cfg(0, 3'd1, 1'b0);
      pin_in[0] = 1'b1;
      step(); chk("R3", "flag0 edge k", 32'(irq_flag[0]), 0);
      step(); chk("R3", "flag0 edge k+1", 32'(irq_flag[0]), 0);
      step(); chk("R3", "flag0 edge k+2", 32'(irq_flag[0]), 1);

      // R4: sticky flag, clear, set wins over clear
      cur_req = "R4";
      pin_in[0] = 1'b0;
      repeat (5) step();
      chk("R4", "flag0 sticky", 32'(irq_flag[0]), 1);
      flag_clr[0] = 1'b1; step(); flag_clr[0] = 1'b0;
      chk("R4", "flag0 cleared", 32'(irq_flag[0]), 0);
      pin_in[0] = 1'b1;
      step(); step();
      flag_clr[0] = 1'b1; step(); flag_clr[0] = 1'b0;
      chk("R4", "set wins over clear", 32'(irq_flag[0]), 1);
      flag_clr[0] = 1'b1; step(); flag_clr[0] = 1'b0;
      chk("R4", "flag0 cleared again", 32'(irq_flag[0]), 0);

      // R5: high level ignores clear
      cur_req = "R5";
      wr_cfg(1, 3'd4, 1'b0);
      pin_in[1] = 1'b1;
      step(); step(); chk("R5", "level flag before latency", 32'(irq_flag[1]), 0);
      step(); chk("R5", "level flag high", 32'(irq_flag[1]), 1);
      flag_clr[1] = 1'b1; step(); flag_clr[1] = 1'b0;
      chk("R5", "clear has no effect on level", 32'(irq_flag[1]), 1);
      pin_in[1] = 1'b0;
      repeat (3) step();
      chk("R5", "level flag follows low", 32'(irq_flag[1]), 0);

      // R2: low level, then invalid code 6 acts as off
      cur_req = "R2";
      wr_cfg(2, 3'd5, 1'b0);
      step(); chk("R2", "low level flag", 32'(irq_flag[2]), 1);
      wr_cfg(2, 3'd6, 1'b0);
      step(); chk("R2", "code 6 forces flag 0", 32'(irq_flag[2]), 0);
      for (int k = 0; k < 6; k++) begin
         pin_in[2] = ~pin_in[2];
         step();
      end
      chk("R2", "code 6 ignores toggles", 32'(irq_flag[2]), 0);

      // R6: deselected pin ignored
      cur_req = "R6";
      wr_cfg(5, 3'd1, 1'b1);
      pin_sel[5] = 1'b0; pin_in[5] = 1'b1;
      repeat (4) step();
      chk("R6", "deselected edge", 32'(irq_flag[5]), 0);
      chk("R6", "deselected wake", 32'(wake_req), 0);
      pin_sel[5] = 1'b1; pin_in[5] = 1'b0;
      repeat (3) step();
      pin_in[5] = 1'b1;
      repeat (3) step();
      chk("R6", "selected edge", 32'(irq_flag[5]), 1);
      flag_clr[5] = 1'b1; wr_cfg(5, 3'd0, 1'b0); flag_clr[5] = 1'b0;

      // R7: wake path with the clock stopped
      cur_req = "R7";
      wr_cfg(3, 3'd1, 1'b1);
      wr_cfg(4, 3'd5, 1'b1);
      wr_cfg(6, 3'd3, 1'b1);
      pin_in[3] = 1'b0; pin_in[4] = 1'b1; pin_in[6] = 1'b0;
      repeat (4) step();
      chk("R7", "wake idle", 32'(wake_req), 0);
      clk_en = 1'b0;
      #20;
      pin_in[3] = 1'b1; #1;
      chk("R7", "wake rise clock stopped", 32'(wake_req), 1);
      chk("R7", "no flag without clock", 32'(irq_flag[3]), 0);
      pin_in[3] = 1'b0; #1;
      chk("R7", "wake rise released", 32'(wake_req), 0);
      pin_in[4] = 1'b0; #1;
      chk("R7", "wake low level", 32'(wake_req), 1);
      pin_in[4] = 1'b1; #1;
      chk("R7", "wake low released", 32'(wake_req), 0);
      pin_in[6] = 1'b1; #1;
      chk("R7", "wake either edge", 32'(wake_req), 1);
      pin_in[6] = 1'b0; #1;
      chk("R7", "wake either edge back", 32'(wake_req), 0);
      clk_en = 1'b1;
      step();

      // R8: non-maskable path
      cur_req = "R8";
      wr_nmi(3'd1);
      nmi_pin = 1'b1;
      step(); step(); chk("R8", "nmi before latency", 32'(nmi_req), 0);
      step(); chk("R8", "nmi rising", 32'(nmi_req), 1);
      nmi_pin = 1'b0;
      repeat (3) step();
      chk("R8", "nmi pending held", 32'(nmi_req), 1);
      nmi_clr = 1'b1; step(); nmi_clr = 1'b0;
      chk("R8", "nmi cleared", 32'(nmi_req), 0);
      pin_sel = '0;
      wr_nmi(3'd4);
      nmi_pin = 1'b1;
      repeat (3) step();
      chk("R8", "nmi level ignores pin_sel", 32'(nmi_req), 1);
      pin_sel = '1;
      wr_nmi(3'd0);
      step(); chk("R8", "nmi off", 32'(nmi_req), 0);
      nmi_pin = 1'b0;

      // R9: random traffic against the model
      cur_req = "R9";
      for (int k = 0; k < 4000; k++) begin
         pin_in   = pin_in ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
         pin_sel  = ~(16'($urandom) & 16'($urandom) & 16'($urandom));
         flag_clr = 16'($urandom) & 16'($urandom);
         cfg_we   = ($urandom % 6) == 0;
         cfg_line = 4'($urandom);
         cfg_sense = 3'($urandom);
         cfg_wake_en = 1'($urandom);
         nmi_pin  = (($urandom % 4) == 0) ? ~nmi_pin : nmi_pin;
         nmi_we   = ($urandom % 20) == 0;
         nmi_sense = 3'($urandom);
         nmi_clr  = ($urandom % 5) == 0;
         step();
      end
      cfg_we = 1'b0; nmi_we = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule